// File: doc/BRIEF.md
# Multi-precision floating-point flag comparator

This block orders two IEEE 754 values and returns the outcome as a four-bit condition code. The code has one form for each of four outcomes: less-than, equal, greater-than and unordered. A two-bit format field chooses half, single or double precision. Narrow operands sit in the low bits of 64-bit buses. A control bit can replace the second operand with positive zero, which turns the block into a sign-and-zero test of the first operand.

Every NaN, quiet or signaling, gives the unordered code and raises the invalid-operation flag. The reserved format code gives an undefined-encoding indication instead of a result. Half precision also counts as undefined while its enable input is low.

The block accepts one compare per cycle under an input valid strobe. It registers all results, so they appear one clock later with a matching output valid.

Top module: `fp_flag_cmp`

## Requirements
- R1: The format field selects the precision: `00` is single (bits 31:0), `01` is double (bits 63:0) and `11` is half (bits 15:0). For half and single, the bits of either bus above the selected width have no effect on any output.
- R2: Format `10`, or format `11` while `half_en` is low, sets `undef` to 1. In that case `flags` is `0000` and `invalid` is 0.
- R3: If either operand is a NaN, quiet or signaling, `flags` is `0011` and `invalid` is 1.
- R4: `flags` is ordered {N,Z,C,V} from bit 3 down to bit 0. Less-than gives `1000`, equal gives `0110` and greater-than gives `0010`. `invalid` is 0 for every ordered result.
- R5: Positive zero and negative zero compare equal, whichever operand carries which sign.
- R6: Infinities order against finite values and against each other. Subnormal values are compared exactly, with no flushing to zero.
- R7: When `zero_sel` is 1, the second operand is positive zero of the selected width, and `opb` has no effect on any output.
- R8: `out_valid` equals the `in_valid` of the previous clock. `flags`, `invalid` and `undef` load only on a valid input and hold their values otherwise.
- R9: A synchronous active-high `rst` clears `out_valid`, `flags`, `invalid` and `undef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| fmt | input | 2 | Precision select: 00 single, 01 double, 11 half, 10 reserved |
| zero_sel | input | 1 | Compare the first operand against positive zero |
| half_en | input | 1 | Enables half-precision support |
| opa | input | 64 | First operand, right-aligned |
| opb | input | 64 | Second operand, right-aligned |
| out_valid | output | 1 | Registered result is new this cycle |
| flags | output | 4 | {N,Z,C,V} condition code |
| invalid | output | 1 | Invalid-operation flag |
| undef | output | 1 | Undefined format encoding |

## Verification
The block has no parameters, so the bench builds it with its fixed 64-bit buses. The bench drives `half_en` both high and low, which reaches both the half-precision compare path and the undefined-encoding path for format `11`. It fills the unused upper bus bits with non-zero junk, which exposes any leakage of those bits into the narrow formats.

// File: rtl/fp_flag_cmp.sv
module fp_flag_cmp (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [1:0]  fmt,
  input  logic        zero_sel,
  input  logic        half_en,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  output logic        out_valid,
  output logic [3:0]  flags,
  output logic        invalid,
  output logic        undef
);

  localparam logic [3:0] C_LT = 4'b1000;
  localparam logic [3:0] C_EQ = 4'b0110;
  localparam logic [3:0] C_GT = 4'b0010;
  localparam logic [3:0] C_UN = 4'b0011;

  logic [63:0] rhs;
  logic        sa, sb, na, nb;
  logic [62:0] ma, mb;
  logic        bad_fmt, any_nan, same, a_less;
  logic [3:0]  code;

  assign rhs = zero_sel ? 64'd0 : opb;

  always_comb begin
    case (fmt)
      2'b11: begin
        sa = opa[15];
        sb = rhs[15];
        ma = {48'd0, opa[14:0]};
        mb = {48'd0, rhs[14:0]};
        na = (&opa[14:10]) && (|opa[9:0]);
        nb = (&rhs[14:10]) && (|rhs[9:0]);
      end
      2'b00: begin
        sa = opa[31];
        sb = rhs[31];
        ma = {32'd0, opa[30:0]};
        mb = {32'd0, rhs[30:0]};
        na = (&opa[30:23]) && (|opa[22:0]);
        nb = (&rhs[30:23]) && (|rhs[22:0]);
      end
      default: begin
        sa = opa[63];
        sb = rhs[63];
        ma = opa[62:0];
        mb = rhs[62:0];
        na = (&opa[62:52]) && (|opa[51:0]);
        nb = (&rhs[62:52]) && (|rhs[51:0]);
      end
    endcase
  end

  assign bad_fmt = (fmt == 2'b10) || (fmt == 2'b11 && !half_en);
  assign any_nan = na || nb;
  assign same    = ((ma == '0) && (mb == '0)) || ((sa == sb) && (ma == mb));
  assign a_less  = (sa != sb) ? sa : (sa ? (ma > mb) : (ma < mb));

  always_comb begin
    if (bad_fmt)      code = 4'b0000;
    else if (any_nan) code = C_UN;
    else if (same)    code = C_EQ;
    else if (a_less)  code = C_LT;
    else              code = C_GT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      flags     <= 4'b0000;
      invalid   <= 1'b0;
      undef     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flags   <= code;
        invalid <= !bad_fmt && any_nan;
        undef   <= bad_fmt;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(flags) && $stable(invalid) && $stable(undef));

  // R2
  undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && undef |-> flags == 4'b0000 && !invalid);

  // R3
  invalid_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !undef |-> invalid == (flags == C_UN));

  // R4
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !undef |-> flags == C_LT || flags == C_EQ || flags == C_GT || flags == C_UN);

  // R2
  reserved_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && fmt == 2'b10 |=> undef);

endmodule

// File: tb/sim_fp_flag_cmp.sv
module sim_fp_flag_cmp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        zero_sel = 1'b0;
  logic        half_en = 1'b1;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        out_valid;
  logic [3:0]  flags;
  logic        invalid;
  logic        undef;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [3:0] LT = 4'b1000;
  localparam logic [3:0] EQ = 4'b0110;
  localparam logic [3:0] GT = 4'b0010;
  localparam logic [3:0] UN = 4'b0011;
  localparam logic [3:0] NO = 4'b0000;

  always #5 clk = ~clk;

  fp_flag_cmp u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt), .zero_sel(zero_sel),
    .half_en(half_en), .opa(opa), .opb(opb), .out_valid(out_valid),
    .flags(flags), .invalid(invalid), .undef(undef)
  );

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,undef,invalid,flags} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag, input logic [1:0] f, input logic z, input logic h,
                     input logic [63:0] a, input logic [63:0] b,
                     input logic [3:0] ef, input logic ei, input logic eu);
    @(negedge clk);
    fmt = f; zero_sel = z; half_en = h; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, undef, invalid, flags}, {1'b1, eu, ei, ef});
  endtask

  task automatic t_reset;
    check("R9 reset", {out_valid, undef, invalid, flags}, 7'd0);
  endtask

  task automatic t_order;
    cmp("R4 half lt",   2'b11, 0, 1, 64'h3C00, 64'h4000, LT, 0, 0);
    cmp("R4 single gt", 2'b00, 0, 1, 64'h40000000, 64'h3F800000, GT, 0, 0);
    cmp("R4 double eq", 2'b01, 0, 1, 64'h3FF0000000000000, 64'h3FF0000000000000, EQ, 0, 0);
    cmp("R4 double neg lt", 2'b01, 0, 1, 64'hC000000000000000, 64'hBFF0000000000000, LT, 0, 0);
    cmp("R4 sign gt",   2'b00, 0, 1, 64'h3F800000, 64'hBF800000, GT, 0, 0);
  endtask

  task automatic t_zero;
    cmp("R5 half +0 -0",   2'b11, 0, 1, 64'h0000, 64'h8000, EQ, 0, 0);
    cmp("R5 double -0 +0", 2'b01, 0, 1, 64'h8000000000000000, 64'h0, EQ, 0, 0);
    cmp("R5 -0 vs 1",      2'b00, 0, 1, 64'h80000000, 64'h3F800000, LT, 0, 0);
  endtask

  task automatic t_special;
    cmp("R6 inf gt max", 2'b01, 0, 1, 64'h7FF0000000000000, 64'h7FEFFFFFFFFFFFFF, GT, 0, 0);
    cmp("R6 -inf lt +inf", 2'b11, 0, 1, 64'hFC00, 64'h7C00, LT, 0, 0);
    cmp("R6 inf eq inf", 2'b00, 0, 1, 64'h7F800000, 64'h7F800000, EQ, 0, 0);
    cmp("R6 -inf lt -max", 2'b00, 0, 1, 64'hFF800000, 64'hFF7FFFFF, LT, 0, 0);
    cmp("R6 subnormal lt", 2'b11, 0, 1, 64'h0001, 64'h0002, LT, 0, 0);
    cmp("R6 subnormal gt 0", 2'b00, 0, 1, 64'h00000001, 64'h0, GT, 0, 0);
    cmp("R6 neg subnormal lt -0", 2'b01, 0, 1, 64'h8000000000000001, 64'h8000000000000000, LT, 0, 0);
  endtask

  task automatic t_nan;
    cmp("R3 half qnan",   2'b11, 0, 1, 64'h7E00, 64'h3C00, UN, 1, 0);
    cmp("R3 single snan", 2'b00, 0, 1, 64'h3F800000, 64'h7F800001, UN, 1, 0);
    cmp("R3 double both", 2'b01, 0, 1, 64'hFFF8000000000000, 64'h7FF0000000000001, UN, 1, 0);
  endtask

  task automatic t_format;
    cmp("R1 single ignores high", 2'b00, 0, 1, 64'hDEADBEEF3F800000, 64'h123456783F800000, EQ, 0, 0);
    cmp("R1 half ignores high",   2'b11, 0, 1, 64'hFFFFFFFFFFFF3C00, 64'h7FF8000000004000, LT, 0, 0);
    cmp("R1 double uses high",    2'b01, 0, 1, 64'h4000000000000000, 64'h3FF0000000000000, GT, 0, 0);
  endtask

  task automatic t_undef;
    cmp("R2 fmt 10",        2'b10, 0, 1, 64'h7FF8000000000000, 64'h0, NO, 0, 1);
    cmp("R2 half disabled", 2'b11, 0, 0, 64'h7E00, 64'h3C00, NO, 0, 1);
    cmp("R2 half enabled",  2'b11, 0, 1, 64'h3C00, 64'h3C00, EQ, 0, 0);
  endtask

  task automatic t_zerosel;
    cmp("R7 pos vs zero",   2'b00, 1, 1, 64'h3F800000, 64'h7FC00000, GT, 0, 0);
    cmp("R7 -0 vs zero",    2'b01, 1, 1, 64'h8000000000000000, 64'hBFF0000000000000, EQ, 0, 0);
    cmp("R7 neg vs zero",   2'b11, 1, 1, 64'hBC00, 64'hFC00, LT, 0, 0);
    cmp("R7 nan vs zero",   2'b00, 1, 1, 64'h7FC00000, 64'h0, UN, 1, 0);
  endtask

  task automatic t_timing;
    cmp("R8 load", 2'b00, 0, 1, 64'h0, 64'h3F800000, LT, 0, 0);
    @(negedge clk);
    opa = 64'h3F800000; opb = 64'h0; fmt = 2'b10;
    @(negedge clk);
    check("R8 idle hold", {out_valid, undef, invalid, flags}, {1'b0, 1'b0, 1'b0, LT});
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears", {out_valid, undef, invalid, flags}, 7'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_order();
    t_zero();
    t_special();
    t_nan();
    t_format();
    t_undef();
    t_zerosel();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule